// File: doc/BRIEF.md
# Command Response Capture and Status Unit

This unit sits between a host register bus and the card-side command sequencer of a memory-card host controller. Software writes a 16-bit command word and a 32-bit argument, the latter as two 16-bit halves. The unit decodes the command word into its index, direction, command class and expected response kind, and presents these to the card side with a one-cycle issue strobe. It then waits for the card exchange to report back.

The card exchange is modelled as a single strobe that carries up to sixteen response bytes and a byte count. A count of zero means that nothing came back. When an answer arrives, the unit packs it into eight 16-bit response words and derives completion and error flags from the response kind. The flags are held in a 15-bit status register and software clears them by writing ones. The interrupt line is the OR of the status bits that are enabled in the 15-bit interrupt-enable register.

Top module: `cmd_resp_ctrl`

## Requirements
- R1: A write with `wr_sel`=1 replaces argument bits 15:0 and a write with `wr_sel`=2 replaces bits 31:16. Each write leaves the other half unchanged.
- R2: A command write (`wr_sel`=0) that is not an index-0 initialization raises `cmd_valid` for exactly the cycle after the write. In that cycle it presents index = bits 5:0, direction = bit 15, class = bits 13:12 and response kind = bits 10:8 of the written word.
- R3: A command write with bit 7 set and index 0 is an initialization. It sets status bit 0 at its own clock edge, raises no `cmd_valid` and waits for no response.
- R4: When an answer with nonzero length is accepted, byte 2i becomes the high half and byte 2i+1 the low half of response word 7-i, for i from 0 to 7. Byte k is `rsp_bytes[8k+7:8k]` and word j is `rsp_words[16j+15:16j]`. The words change at no other time.
- R5: For response kind 3 (operating conditions), status bit 12 is set when bit 31 of the 32-bit value {byte0,byte1,byte2,byte3} is clear.
- R6: For response kind 1 (normal), status bit 14 is set when the same 32-bit value has any bit set in the error mask 0xFDF80000.
- R7: For response kind 6 (published address), status bit 14 is set when the 16-bit value {byte2,byte3} has any bit set in 0xE000.
- R8: When a response kind other than 0 is pending and the answer has length 0, status bit 7 (timeout) is set. The response words keep their previous contents.
- R9: Status bit 0 (end of command) is set on every accepted answer, including timeouts and kind 0.
- R10: A response strobe while no command is pending has no effect on status or response words.
- R11: `wr_sel`=4 loads the interrupt-enable mask from bits 14:0. `irq` is high in the same cycle whenever (status AND mask) is nonzero.
- R12: A write with `wr_sel`=3 clears each status bit written as 1. A flag set in the same cycle wins over the clear, and bits not written as 1 are kept.
- R13: Response kinds 0 and 2 never set bits 12 or 14, and kind 0 with length 0 does not set bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 command, 1 argument low, 2 argument high, 3 status clear, 4 interrupt enable |
| wr_data | input | 16 | Write data |
| rsp_valid | input | 1 | Card exchange finished, answer on `rsp_bytes`/`rsp_len` |
| rsp_len | input | 5 | Number of response bytes, 0 = no answer |
| rsp_bytes | input | 128 | Response bytes, byte k at bits 8k+7:8k |
| cmd_valid | output | 1 | One-cycle command issue strobe |
| cmd_index | output | 6 | Command index |
| cmd_dir | output | 1 | Data direction |
| cmd_ctype | output | 2 | Command class |
| cmd_rtype | output | 3 | Expected response kind |
| cmd_arg | output | 32 | Command argument |
| rsp_words | output | 128 | Eight response words, word j at bits 16j+15:16j |
| status | output | 15 | Status flags |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a status clear and a new flag landing on the same clock edge. The bench gets there by issuing a command, then driving the status-clear write and the response strobe together in one cycle, and checking that bit 0 survives. A second hard case is a response strobe with no command pending. The bench sends an error-laden answer after a finished command and checks that the status flags and all eight response words stay the same.

// File: rtl/cmdrsp_pkg.sv
// Package: shared encodings for the command response capture unit.
// Assumes: register-select and response-kind codes are fixed by software.
package cmdrsp_pkg;

    typedef enum logic [2:0] {
        SEL_CMD    = 3'd0,
        SEL_ARG_LO = 3'd1,
        SEL_ARG_HI = 3'd2,
        SEL_STAT   = 3'd3,
        SEL_IE     = 3'd4
    } reg_sel_e;

    typedef enum logic [2:0] {
        RK_NONE   = 3'd0,
        RK_NORMAL = 3'd1,
        RK_LONG   = 3'd2,
        RK_OPCOND = 3'd3,
        RK_ADDR   = 3'd6
    } rsp_kind_e;

    localparam int ST_DONE    = 0;
    localparam int ST_TIMEOUT = 7;
    localparam int ST_OPCOND  = 12;
    localparam int ST_CARDERR = 14;

endpackage

// File: rtl/cmdrsp_host_regs.sv
// Module: host-side registers. Holds the argument, the interrupt-enable mask,
// decodes command writes, emits the issue strobe and tracks the pending command.
// Assumes: HALF_W-bit writes; the argument is two halves wide.
module cmdrsp_host_regs
    import cmdrsp_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int STAT_W = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [HALF_W-1:0]   wr_data,
    input  logic                rsp_valid,
    output logic                rsp_accept,
    output logic                init_hit,
    output logic                cmd_valid,
    output logic [5:0]          cmd_index,
    output logic                cmd_dir,
    output logic [1:0]          cmd_ctype,
    output logic [2:0]          cmd_rtype,
    output logic [2*HALF_W-1:0] cmd_arg,
    output logic [STAT_W-1:0]   ie_mask
);
    localparam int ARG_W = 2 * HALF_W;

    logic pending;
    logic cmd_wr;

    // Decode a command write and spot the initialization shortcut.
    assign cmd_wr     = wr_en && (reg_sel_e'(wr_sel) == SEL_CMD);
    assign init_hit   = cmd_wr && wr_data[7] && (wr_data[5:0] == 6'd0);
    assign rsp_accept = rsp_valid && pending;

    // Register updates, issue strobe and pending tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_arg   <= '0;
            ie_mask   <= '0;
            cmd_valid <= 1'b0;
            cmd_index <= '0;
            cmd_dir   <= 1'b0;
            cmd_ctype <= '0;
            cmd_rtype <= '0;
            pending   <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (rsp_accept) pending <= 1'b0;
            if (wr_en) begin
                case (reg_sel_e'(wr_sel))
                    SEL_CMD: begin
                        if (init_hit) begin
                            pending <= 1'b0;
                        end else begin
                            cmd_valid <= 1'b1;
                            cmd_index <= wr_data[5:0];
                            cmd_dir   <= wr_data[15];
                            cmd_ctype <= wr_data[13:12];
                            cmd_rtype <= wr_data[10:8];
                            pending   <= 1'b1;
                        end
                    end
                    SEL_ARG_LO: cmd_arg[HALF_W-1:0]     <= wr_data;
                    SEL_ARG_HI: cmd_arg[ARG_W-1:HALF_W] <= wr_data;
                    SEL_IE:     ie_mask <= wr_data[STAT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // R2: an issue strobe always follows a command write.
    assert_strobe_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(wr_en && (wr_sel == SEL_CMD)));

    // R3: an initialization command never issues to the card.
    assert_init_no_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        init_hit |=> !cmd_valid);

    // R1: a low-half write leaves the high half alone.
    assert_arg_high_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_ARG_LO) |=> $stable(cmd_arg[ARG_W-1:HALF_W]));

endmodule

// File: rtl/cmdrsp_rsp_pack.sv
// Module: packs response bytes into response words, pairs in reversed word order.
// Assumes: byte 2i is the high half of word NWORDS-1-i.
module cmdrsp_rsp_pack #(
    parameter int NWORDS = 8,
    parameter int WORD_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [NWORDS*WORD_W-1:0] bytes_in,
    output logic [NWORDS*WORD_W-1:0] words
);
    localparam int HB = WORD_W / 2;

    for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
        // Capture byte pair gi into the mirrored word slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[(NWORDS-1-gi)*WORD_W +: WORD_W] <= '0;
            else if (load)
                words[(NWORDS-1-gi)*WORD_W +: WORD_W] <=
                    {bytes_in[(2*gi)*HB +: HB], bytes_in[(2*gi+1)*HB +: HB]};
        end
    end

    // R4: the words move only when an answer is loaded.
    assert_words_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(words));

endmodule

// File: rtl/cmdrsp_status.sv
// Module: status flags with write-one-to-clear and the masked interrupt.
// Assumes: header is {byte0,byte1,byte2,byte3}; set events win over clears.
module cmdrsp_status
    import cmdrsp_pkg::*;
#(
    parameter int          STAT_W   = 15,
    parameter logic [31:0] ERR_MASK = 32'hFDF8_0000,
    parameter logic [15:0] RCA_MASK = 16'hE000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [STAT_W-1:0] clr_bits,
    input  logic              init_hit,
    input  logic              rsp_accept,
    input  logic              rsp_none,
    input  logic [2:0]        rtype,
    input  logic [31:0]       hdr,
    input  logic [STAT_W-1:0] ie_mask,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;

    // Derive the flags raised by this cycle's events.
    always_comb begin
        set_vec = '0;
        if (init_hit) set_vec[ST_DONE] = 1'b1;
        if (rsp_accept) begin
            set_vec[ST_DONE] = 1'b1;
            if (rsp_none) begin
                if (rsp_kind_e'(rtype) != RK_NONE) set_vec[ST_TIMEOUT] = 1'b1;
            end else begin
                case (rsp_kind_e'(rtype))
                    RK_NORMAL: if ((hdr & ERR_MASK) != 32'd0) set_vec[ST_CARDERR] = 1'b1;
                    RK_OPCOND: if (!hdr[31]) set_vec[ST_OPCOND] = 1'b1;
                    RK_ADDR:   if ((hdr[15:0] & RCA_MASK) != 16'd0) set_vec[ST_CARDERR] = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assign clr_vec = clr_en ? clr_bits : '0;

    // Status register: clear requested bits, then merge new flags.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | set_vec;
    end

    // Interrupt is the live OR of enabled flags.
    assign irq = |(status & ie_mask);

    // R8: a timeout flag appears only after an empty answer.
    assert_timeout_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_TIMEOUT]) |-> $past(rsp_accept && rsp_none));

    // R12: without a clear, no flag drops.
    assert_flags_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((status & $past(status)) == $past(status)));

    // R12: a clear with no competing event empties the written bits.
    assert_clear_works_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !rsp_accept && !init_hit) |=> ((status & $past(clr_bits)) == '0));

    // R10: with nothing to accept and no init, no flag rises.
    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_accept && !init_hit) |=> ((status & ~$past(status)) == '0));

endmodule

// File: rtl/cmd_resp_ctrl.sv
// Module: top of the command response capture unit. Wires the host registers,
// response packer and status logic together.
// Assumes: the card side answers each issued command with one rsp_valid strobe.
module cmd_resp_ctrl
    import cmdrsp_pkg::*;
#(
    parameter int NWORDS = 8,
    parameter int WORD_W = 16,
    parameter int STAT_W = 15
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [2:0]                             wr_sel,
    input  logic [WORD_W-1:0]                      wr_data,
    input  logic                                   rsp_valid,
    input  logic [$clog2(NWORDS*WORD_W/8+1)-1:0]   rsp_len,
    input  logic [NWORDS*WORD_W-1:0]               rsp_bytes,
    output logic                                   cmd_valid,
    output logic [5:0]                             cmd_index,
    output logic                                   cmd_dir,
    output logic [1:0]                             cmd_ctype,
    output logic [2:0]                             cmd_rtype,
    output logic [2*WORD_W-1:0]                    cmd_arg,
    output logic [NWORDS*WORD_W-1:0]               rsp_words,
    output logic [STAT_W-1:0]                      status,
    output logic                                   irq
);
    logic              rsp_accept;
    logic              init_hit;
    logic              rsp_none;
    logic [STAT_W-1:0] ie_mask;
    logic [31:0]       hdr;
    logic              clr_en;

    // Header word and event qualifiers shared by the sub-blocks.
    assign hdr      = {rsp_bytes[7:0], rsp_bytes[15:8], rsp_bytes[23:16], rsp_bytes[31:24]};
    assign rsp_none = (rsp_len == '0);
    assign clr_en   = wr_en && (reg_sel_e'(wr_sel) == SEL_STAT);

    cmdrsp_host_regs #(.HALF_W(WORD_W), .STAT_W(STAT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rsp_valid  (rsp_valid),
        .rsp_accept (rsp_accept),
        .init_hit   (init_hit),
        .cmd_valid  (cmd_valid),
        .cmd_index  (cmd_index),
        .cmd_dir    (cmd_dir),
        .cmd_ctype  (cmd_ctype),
        .cmd_rtype  (cmd_rtype),
        .cmd_arg    (cmd_arg),
        .ie_mask    (ie_mask)
    );

    cmdrsp_rsp_pack #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rsp_accept && !rsp_none),
        .bytes_in (rsp_bytes),
        .words    (rsp_words)
    );

    cmdrsp_status #(.STAT_W(STAT_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_en     (clr_en),
        .clr_bits   (wr_data[STAT_W-1:0]),
        .init_hit   (init_hit),
        .rsp_accept (rsp_accept),
        .rsp_none   (rsp_none),
        .rtype      (cmd_rtype),
        .hdr        (hdr),
        .ie_mask    (ie_mask),
        .status     (status),
        .irq        (irq)
    );

endmodule

// File: tb/sim_cmd_resp_ctrl.sv
// Bench: directed scenarios for cmd_resp_ctrl, one task per scenario.
module sim_cmd_resp_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_sel = '0;
    logic [15:0]  wr_data = '0;
    logic         rsp_valid = 1'b0;
    logic [4:0]   rsp_len = '0;
    logic [127:0] rsp_bytes = '0;
    logic         cmd_valid;
    logic [5:0]   cmd_index;
    logic         cmd_dir;
    logic [1:0]   cmd_ctype;
    logic [2:0]   cmd_rtype;
    logic [31:0]  cmd_arg;
    logic [127:0] rsp_words;
    logic [14:0]  status;
    logic         irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cmd_resp_ctrl u0 (.*);

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic answer(input logic [127:0] b, input logic [4:0] n);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_bytes = b; rsp_len = n;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic clear_all();
        wr(3'd3, 16'h7FFF);
    endtask

    task automatic t_reset();
        chk("R12 reset status", status, 0);
        chk("R11 reset irq", irq, 0);
        chk("R1 reset arg", cmd_arg, 0);
        chk("R4 reset words", rsp_words, 0);
        chk("R2 reset strobe", cmd_valid, 0);
    endtask

    task automatic t_arg_R1();
        wr(3'd1, 16'h1234);
        wr(3'd2, 16'hABCD);
        chk("R1 both halves", cmd_arg, 32'hABCD1234);
        wr(3'd1, 16'h5678);
        chk("R1 low only", cmd_arg, 32'hABCD5678);
    endtask

    task automatic t_decode_R2();
        wr(3'd0, 16'hA111);
        chk("R2 strobe", cmd_valid, 1);
        chk("R2 fields", {cmd_index, cmd_dir, cmd_ctype, cmd_rtype}, {6'd17, 1'b1, 2'd2, 3'd1});
        @(negedge clk);
        chk("R2 strobe one cycle", cmd_valid, 0);
    endtask

    task automatic t_normal_R6();
        answer(128'h0009_0000, 5'd6);
        chk("R6 clean answer, R9 done", status, 15'h0001);
        clear_all();
        wr(3'd0, 16'h0111);
        answer(128'h80, 5'd6);
        chk("R6 card error", status, 15'h4001);
        clear_all();
    endtask

    task automatic t_pack_R4();
        logic [127:0] b;
        logic [127:0] e;
        for (int k = 0; k < 16; k++) b[8*k +: 8] = 8'hF0 + 8'(k);
        for (int i = 0; i < 8; i++) e[16*(7-i) +: 16] = {8'hF0 + 8'(2*i), 8'hF0 + 8'(2*i+1)};
        wr(3'd0, 16'h0202);
        answer(b, 5'd16);
        chk("R4 packing", rsp_words, e);
        chk("R13 long kind no error", status, 15'h0001);
        clear_all();
    endtask

    task automatic t_opcond_R5();
        wr(3'd0, 16'h0301);
        answer(128'h00FF_8000, 5'd6);
        chk("R5 busy clear", status, 15'h1001);
        clear_all();
        wr(3'd0, 16'h0301);
        answer(128'h80, 5'd6);
        chk("R5 ready", status, 15'h0001);
        clear_all();
    endtask

    task automatic t_addr_R7();
        wr(3'd0, 16'h0603);
        answer(128'h0020_0000, 5'd6);
        chk("R7 address error", status, 15'h4001);
        clear_all();
        wr(3'd0, 16'h0603);
        answer(128'hFF1F_0000, 5'd6);
        chk("R7 clean", status, 15'h0001);
        clear_all();
    endtask

    task automatic t_timeout_R8();
        logic [127:0] prev;
        prev = rsp_words;
        wr(3'd0, 16'h0105);
        answer(128'hFFFF, 5'd0);
        chk("R8 timeout flag", status, 15'h0081);
        chk("R8 words kept", rsp_words, prev);
        clear_all();
        wr(3'd0, 16'h0006);
        answer('0, 5'd0);
        chk("R13 kind 0 no timeout, R9 done", status, 15'h0001);
        clear_all();
    endtask

    task automatic t_init_R3();
        wr(3'd0, 16'h0080);
        chk("R3 done at once", status, 15'h0001);
        chk("R3 no strobe", cmd_valid, 0);
        clear_all();
    endtask

    task automatic t_ignore_R10();
        logic [127:0] prev;
        prev = rsp_words;
        answer(128'hAA_0000_0080, 5'd8);
        chk("R10 status untouched", status, 0);
        chk("R10 words untouched", rsp_words, prev);
    endtask

    task automatic t_irq_R11();
        wr(3'd0, 16'h0080);
        wr(3'd4, 16'h0080);
        chk("R11 masked off", irq, 0);
        wr(3'd4, 16'h0001);
        chk("R11 enabled", irq, 1);
        clear_all();
        chk("R11 follows clear", irq, 0);
    endtask

    task automatic t_race_R12();
        wr(3'd0, 16'h0007);
        wr(3'd0, 16'h0080);
        wr(3'd0, 16'h0007);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd3; wr_data = 16'h0001;
        rsp_valid = 1'b1; rsp_bytes = '0; rsp_len = 5'd0;
        @(negedge clk);
        wr_en = 1'b0; rsp_valid = 1'b0;
        chk("R12 set wins over clear", status, 15'h0001);
        wr(3'd3, 16'h0080);
        chk("R12 unwritten bit kept", status, 15'h0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arg_R1();
        t_decode_R2();
        t_normal_R6();
        t_pack_R4();
        t_opcond_R5();
        t_addr_R7();
        t_timeout_R8();
        t_init_R3();
        t_ignore_R10();
        t_irq_R11();
        t_race_R12();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule